// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a register-driven I2C master that moves exactly one bus byte per command word. Software writes a command word that can ask for a START ahead of the byte, for a STOP instead of a byte, and for the acknowledge value the master returns. The engine then clocks nine SCL pulses on open-drain lines and raises a level interrupt when the byte is done. There is no busy bit to poll. A status word returns the eight bits seen on SDA, the acknowledge bit seen in the ninth slot, a lost-arbitration flag and a bus-held flag.

A read is set up by a START command whose address byte has bit 0 high. Later byte commands without START then release SDA for the eight data bits and drive the acknowledge slot from the command's NACK bit. A START issued while the master still holds the bus produces a repeated START. A configuration word holds the SCL high time in its upper half and the full SCL period in its lower half. It can be changed only while the bus logic is held in reset through the bus-control register.

Top module: `i2cb_master`

## Requirements
- R1: After reset, both line drivers are off, irq is 0, the status word reads 0, the bus-control register reads 0 (bus logic held) and the timing word reads {DEF_HI, DEF_PER}.
- R2: A command word (offset 0) with bit 10 set produces a START (SDA falls while SCL is high) and then sends bits 7..0 of the word MSB first. The master's ack-slot drive is low only when bit 8 is 0. Status (offset 1) bit 11 reads 0 when the slave pulled SDA low in the ack slot.
- R3: When no slave acknowledges, status bit 11 reads 1.
- R4: In write direction, data bytes go out MSB first, and status bits 7..0 return the eight SDA samples of the last byte.
- R5: After a START byte whose bit 0 is 1, byte commands release SDA for the data bits. Status bits 7..0 hold the byte the slave sent. The master drives the ack slot low when command bit 8 is 0 and releases it when bit 8 is 1.
- R6: A command with bit 9 set produces a STOP and no data bits. Afterwards both lines are released and status bit 12 reads 0.
- R7: A START command issued while the bus is held produces a repeated START, with no STOP in between.
- R8: If SDA reads low while the master sends a 1 in a data bit, the master releases both lines at once and sends no STOP. Status bit 9 reads 1, status bit 12 reads 0 and irq rises.
- R9: irq rises when a byte, a STOP or a lost arbitration completes. It stays high until any register write, for example to offset 4. A completion in the same cycle as a write leaves irq high.
- R10: Timing word (offset 2) bits 31..16 give the SCL high time and bits 15..0 the SCL period, in clk cycles. Writes to it are ignored unless the bus logic is held.
- R11: Bus-control register (offset 3): the bus logic runs only when bits 1..0 are 3. Any other value holds it idle, releases both lines and ignores command writes.
- R12: Between byte commands the master holds SCL low, and status bit 12 reads 1 from a START until a STOP or lost arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion interrupt level |
| scl_drive_low | output | 1 | Open-drain SCL pull-down enable |
| sda_drive_low | output | 1 | Open-drain SDA pull-down enable |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The interrupt is set by the engine's completion and cleared by any register write, and these two can land in the same clock. To force that, the bench holds a write to the clear offset asserted on every cycle while a byte is in flight, so completion must coincide with a write. It then expects irq to be high for exactly one sample before the next write clears it. A second pairing, a lost arbitration against the master's own data bit, is provoked by pulling SDA low from the bench during a bit the master sends as 1. That case is judged from the status flags and the released line drivers.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
// Package: register offsets, command/status bit positions and engine states
// shared by the byte-command I2C master.
package i2cb_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TIME = 3'd2;
    localparam logic [REG_AW-1:0] OFS_BUS  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_ACK  = 3'd4;

    localparam int CMD_STA  = 10;
    localparam int CMD_STO  = 9;
    localparam int CMD_NACK = 8;

    localparam int ST_HELD = 12;
    localparam int ST_RACK = 11;
    localparam int ST_LOST = 9;

    typedef enum logic [3:0] {
        E_IDLE, E_START, E_RS_LO, E_RS_HI, E_BIT_LO, E_BIT_HI,
        E_HOLD, E_STOP_LO, E_STOP_HI
    } eng_state_t;
endpackage

// File: rtl/i2cb_engine.sv
`timescale 1ns/1ps
// Bit-level SCL/SDA sequencer. Runs one START+byte, byte, or STOP per go
// pulse. Assumes scl_in/sda_in are already synchronised to clk and that
// go arrives only while ready is high. SDA changes one clk after SCL
// falls, so data never moves while SCL is high.
module i2cb_engine
    import i2cb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             go,
    input  logic             go_sta,
    input  logic             go_sto,
    input  logic             go_nack,
    input  logic [7:0]       go_data,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] per_cfg,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done,
    output logic             ready,
    output logic             owned,
    output logic             lost,
    output logic             rack,
    output logic [7:0]       rx
);
    eng_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       bitn;
    logic [7:0]       data_q;
    logic             nack_q, addr_byte, rd_mode;
    logic [CNT_W:0]   hi_len, lo_len;
    logic             tx_bit, sending, sda_want;

    // Phase lengths with floors: high >= 1 cycle, low >= 2 cycles.
    always_comb begin
        hi_len = (hi_cfg == '0) ? (CNT_W+1)'(1) : {1'b0, hi_cfg};
        lo_len = ({1'b0, per_cfg} > hi_len + 1) ? ({1'b0, per_cfg} - hi_len)
                                                : (CNT_W+1)'(2);
    end

    // Bit the master puts out for the current data slot.
    always_comb begin
        sending = addr_byte || !rd_mode;
        tx_bit  = sending ? data_q[3'(4'd7 - bitn)] : 1'b1;
    end

    // SDA pull-down wanted by the present state.
    always_comb begin
        case (state)
            E_START, E_STOP_LO, E_STOP_HI: sda_want = 1'b1;
            E_BIT_LO, E_BIT_HI:            sda_want = (bitn < 4'd8) ? !tx_bit : !nack_q;
            default:                       sda_want = 1'b0;
        endcase
    end

    // SCL pull-down decoded straight from state.
    always_comb begin
        scl_low = (state == E_RS_LO) || (state == E_BIT_LO) ||
                  (state == E_HOLD)  || (state == E_STOP_LO);
        ready   = (state == E_IDLE) || (state == E_HOLD);
    end

    // SDA register: lags state by one cycle to keep data off SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) sda_low <= 1'b0;
        else                sda_low <= sda_want;
    end

    // Main sequencer: phase counter, bit counter and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state <= E_IDLE; cnt <= '0; bitn <= '0; data_q <= '0;
            nack_q <= 1'b1; addr_byte <= 1'b0; rd_mode <= 1'b0;
            done <= 1'b0; owned <= 1'b0; lost <= 1'b0; rack <= 1'b0; rx <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                E_IDLE, E_HOLD: if (go) begin
                    data_q <= go_data;
                    nack_q <= go_nack;
                    lost   <= 1'b0;
                    bitn   <= '0;
                    if (go_sto) begin
                        state <= E_STOP_LO; cnt <= CNT_W'(lo_len - 1);
                    end else if (go_sta) begin
                        addr_byte <= 1'b1;
                        rd_mode   <= go_data[0];
                        owned     <= 1'b1;
                        if (owned) begin state <= E_RS_LO; cnt <= CNT_W'(lo_len - 1); end
                        else       begin state <= E_START; cnt <= CNT_W'(hi_len - 1); end
                    end else begin
                        addr_byte <= 1'b0;
                        state <= E_BIT_LO; cnt <= CNT_W'(lo_len - 1);
                    end
                end
                E_RS_LO:
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_RS_HI; cnt <= CNT_W'(hi_len - 1); end
                E_RS_HI: if (scl_in) begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_START; cnt <= CNT_W'(hi_len - 1); end
                end
                E_START:
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_BIT_LO; cnt <= CNT_W'(lo_len - 1); end
                E_BIT_LO:
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_BIT_HI; cnt <= CNT_W'(hi_len - 1); end
                E_BIT_HI: if (scl_in) begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else if (bitn == 4'd8) begin
                        rack <= sda_in; state <= E_HOLD; done <= 1'b1;
                    end else if (sending && tx_bit && !sda_in) begin
                        rx <= {rx[6:0], sda_in};
                        lost <= 1'b1; owned <= 1'b0; state <= E_IDLE; done <= 1'b1;
                    end else begin
                        rx <= {rx[6:0], sda_in};
                        bitn <= bitn + 1'b1;
                        state <= E_BIT_LO; cnt <= CNT_W'(lo_len - 1);
                    end
                end
                E_STOP_LO:
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_STOP_HI; cnt <= CNT_W'(hi_len - 1); end
                E_STOP_HI: if (scl_in) begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin state <= E_IDLE; owned <= 1'b0; done <= 1'b1; end
                end
                default: state <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cb_regs.sv
`timescale 1ns/1ps
// Register file: command decode into a go pulse, timing word, bus-control
// register, interrupt level and the read mux. Assumes one access per cycle.
module i2cb_regs
    import i2cb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DEF_HI  = 4,
    parameter int DEF_PER = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic              eng_owned,
    input  logic              eng_lost,
    input  logic              eng_rack,
    input  logic [7:0]        eng_rx,
    output logic              run,
    output logic              go,
    output logic              go_sta,
    output logic              go_sto,
    output logic              go_nack,
    output logic [7:0]        go_data,
    output logic [2*CNT_W-1:0] time_cfg,
    output logic              irq
);
    logic [1:0] bus_ctl;

    // Bus logic runs only with both control bits set.
    always_comb run = (bus_ctl == 2'b11);

    // Command decode: accepted only while running and the engine is ready.
    always_comb begin
        go      = reg_we && (reg_addr == OFS_CMD) && run && eng_ready;
        go_sta  = reg_wdata[CMD_STA];
        go_sto  = reg_wdata[CMD_STO];
        go_nack = reg_wdata[CMD_NACK];
        go_data = reg_wdata[7:0];
    end

    // Timing word and bus-control register; timing locked while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_cfg <= {CNT_W'(DEF_HI), CNT_W'(DEF_PER)};
            bus_ctl  <= 2'b00;
        end else if (reg_we) begin
            if (reg_addr == OFS_TIME && !run) time_cfg <= reg_wdata[2*CNT_W-1:0];
            if (reg_addr == OFS_BUS)          bus_ctl  <= reg_wdata[1:0];
        end
    end

    // Interrupt level: completion sets (wins), any register write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (eng_done) irq <= 1'b1;
        else if (reg_we)   irq <= 1'b0;
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT: begin
                reg_rdata[7:0]     = eng_rx;
                reg_rdata[ST_LOST] = eng_lost;
                reg_rdata[ST_RACK] = eng_rack;
                reg_rdata[ST_HELD] = eng_owned;
            end
            OFS_TIME: reg_rdata[2*CNT_W-1:0] = time_cfg;
            OFS_BUS:  reg_rdata[1:0] = bus_ctl;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cb_master.sv
`timescale 1ns/1ps
// Top: byte-command I2C master. Register block plus bit sequencer.
// Assumes external pull-ups and synchronised line inputs.
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DEF_HI  = 4,
    parameter int DEF_PER = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              scl_in,
    input  logic              sda_in
);
    localparam int TIME_W = 2 * CNT_W;

    logic              bus_run, go, go_sta, go_sto, go_nack;
    logic [7:0]        go_data, eng_rx;
    logic [TIME_W-1:0] time_cfg;
    logic              eng_ready, eng_done, eng_owned, eng_lost, eng_rack;

    i2cb_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_PER(DEF_PER)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_owned(eng_owned),
        .eng_lost(eng_lost), .eng_rack(eng_rack), .eng_rx(eng_rx),
        .run(bus_run), .go(go), .go_sta(go_sta), .go_sto(go_sto),
        .go_nack(go_nack), .go_data(go_data), .time_cfg(time_cfg), .irq(irq)
    );

    i2cb_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(bus_run), .go(go), .go_sta(go_sta),
        .go_sto(go_sto), .go_nack(go_nack), .go_data(go_data),
        .hi_cfg(time_cfg[TIME_W-1:CNT_W]), .per_cfg(time_cfg[CNT_W-1:0]),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low), .done(eng_done),
        .ready(eng_ready), .owned(eng_owned), .lost(eng_lost),
        .rack(eng_rack), .rx(eng_rx)
    );
endmodule

// File: rtl/i2cb_master_chk.sv
`timescale 1ns/1ps
// Checker bound to i2cb_master: temporal rules between registers,
// sequencer and line drivers.
module i2cb_master_chk #(
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_run,
    input logic              scl_drive_low,
    input logic              sda_drive_low,
    input logic              irq,
    input logic              reg_we,
    input logic              eng_done,
    input logic              eng_owned,
    input logic              eng_lost,
    input logic [TIME_W-1:0] time_cfg
);
    // R11
    held_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_run |-> (!scl_drive_low && !sda_drive_low));

    // R8
    lost_releases_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_lost) |-> (!scl_drive_low && !sda_drive_low));

    // R6
    bus_free_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_owned) |-> !scl_drive_low);

    // R9
    write_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !eng_done) |=> !irq);

    // R9
    done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> irq);

    // R10
    timing_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_run && $past(bus_run)) |-> $stable(time_cfg));
endmodule

bind i2cb_master i2cb_master_chk #(.TIME_W(2*CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_run(bus_run),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .irq(irq), .reg_we(reg_we), .eng_done(eng_done),
    .eng_owned(eng_owned), .eng_lost(eng_lost), .time_cfg(time_cfg)
);

// File: tb/i2cb_master_test.sv
`timescale 1ns/1ps
module i2cb_master_test;
    localparam logic [6:0] SADDR = 7'h50;
    // Vector: cmd[23:12], expected rx[11:4], check rx[3], expected ack[2], check ack[1]
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {12'h5A0, 8'hA0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 start + write address
        {12'h13C, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 data
        {12'h1C3, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 data
        {12'h5A1, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b0},  // R7 repeated start, read
        {12'h000, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 read, master ACK
        {12'h100, 8'hA6, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 read, master NACK
        {12'h300, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}   // R6 stop
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic s_low = 1'b0, other_low = 1'b0;
    wire  scl_line = !scl_oe;
    wire  sda_line = !(sda_oe || s_low || other_low);
    int   n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    i2cb_master uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_drive_low(scl_oe), .sda_drive_low(sda_oe),
        .scl_in(scl_line), .sda_in(sda_line)
    );

    // Behavioural slave answering SADDR.
    int starts = 0, stops = 0, wcnt = 0, mcnt = 0, bitcnt = 0;
    bit active = 0, first = 0, addressed = 0, rdm = 0, mack = 0;
    logic [7:0] shreg = '0, tx = '0, next_rd = 8'hA5;
    logic [7:0] mem [4];
    bit mlog [4];

    always @(negedge sda_line) if (scl_line) begin
        active = 1; first = 1; bitcnt = 0; s_low = 0; starts++;
    end
    always @(posedge sda_line) if (scl_line && active) begin
        active = 0; s_low = 0; stops++;
    end
    always @(posedge scl_line) if (active) begin
        if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
        else if (bitcnt == 8) mack = sda_line;
        bitcnt++;
    end
    always @(negedge scl_line) if (active) begin
        if (bitcnt == 8) begin
            if (first) begin
                addressed = (shreg[7:1] == SADDR); rdm = shreg[0]; s_low = addressed;
            end else if (addressed && !rdm) begin
                if (wcnt < 4) mem[wcnt] = shreg;
                wcnt++; s_low = 1;
            end else s_low = 0;
        end else if (bitcnt == 9) begin
            bitcnt = 0;
            if (addressed && rdm && !first) begin
                if (mcnt < 4) mlog[mcnt] = mack;
                mcnt++;
            end
            if (addressed && rdm && (first || !mack)) begin
                tx = next_rd; next_rd = next_rd + 1; s_low = !tx[7];
            end else s_low = 0;
            first = 0;
        end else if (bitcnt >= 1 && bitcnt <= 7 && addressed && rdm && !first)
            s_low = !tx[7 - bitcnt];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int i = 0; i < 4000 && !ok; i++) begin
            @(negedge clk);
            if (irq) ok = 1;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok;
        int seen, hi_m, per_m, n;
        bit idle_ok;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 scl_oe", 32'(scl_oe), 0);
        check("R1 sda_oe", 32'(sda_oe), 0);
        check("R1 irq", 32'(irq), 0);
        rd(3'd1, d); check("R1 status", d, 0);
        rd(3'd3, d); check("R1 busctl", d, 0);
        rd(3'd2, d); check("R1 timing", d, 32'h0004_000A);

        wr(3'd3, 32'd3);
        // R10 timing write while running is ignored
        wr(3'd2, 32'h0007_0020);
        rd(3'd2, d); check("R10 locked timing", d, 32'h0004_000A);

        // Table walk: R2 R4 R5 R6 R7 R12
        for (int v = 0; v < NV; v++) begin
            logic [11:0] cmd;
            cmd = VEC[v][23:12];
            wr(3'd0, {20'd0, cmd});
            wait_irq(ok);
            check($sformatf("R2 irq vec%0d", v), 32'(ok), 1);
            repeat (20) @(negedge clk);
            check($sformatf("R9 irq held vec%0d", v), 32'(irq), 1);
            rd(3'd1, d);
            if (VEC[v][3]) check($sformatf("R4 R5 rx vec%0d", v), 32'(d[7:0]), 32'(VEC[v][11:4]));
            if (VEC[v][1]) check($sformatf("R2 R3 ack vec%0d", v), 32'(d[11]), 32'(VEC[v][2]));
            if (cmd[9]) begin
                check("R6 held flag", 32'(d[12]), 0);
                check("R6 lines", {30'd0, scl_line, sda_line}, 32'd3);
            end else begin
                check($sformatf("R12 held flag vec%0d", v), 32'(d[12]), 1);
                check($sformatf("R12 scl low vec%0d", v), 32'(scl_line), 0);
            end
            wr(3'd4, 32'd1);
            check($sformatf("R9 cleared vec%0d", v), 32'(irq), 0);
        end
        check("R4 slave byte0", 32'(mem[0]), 32'h3C);
        check("R4 slave byte1", 32'(mem[1]), 32'hC3);
        check("R5 master ack", 32'(mlog[0]), 0);
        check("R5 master nack", 32'(mlog[1]), 1);
        check("R7 starts", 32'(starts), 2);
        check("R6 stops", 32'(stops), 1);

        // R3 unanswered address
        wr(3'd0, 32'h546);
        wait_irq(ok);
        rd(3'd1, d); check("R3 no ack", 32'(d[11]), 1);
        wr(3'd0, 32'h300); wait_irq(ok); wr(3'd4, 1);

        // R11 held bus ignores commands
        for (int b = 0; b < 3; b++) begin
            wr(3'd3, 32'(b));
            wr(3'd0, 32'h5A0);
            idle_ok = 1;
            repeat (200) begin
                @(negedge clk);
                if (!scl_line || !sda_line || irq) idle_ok = 0;
            end
            check($sformatf("R11 idle ctl%0d", b), 32'(idle_ok), 1);
        end

        // R10 new timing while held, then measure
        wr(3'd2, 32'h0006_0010);
        wr(3'd3, 32'd3);
        rd(3'd2, d); check("R10 timing readback", d, 32'h0006_0010);
        wr(3'd0, 32'h5A0);
        @(posedge scl_line);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (scl_line);
        hi_m = n;
        do begin @(posedge clk); #1; n++; end while (!scl_line);
        per_m = n;
        check("R10 scl high", 32'(hi_m), 6);
        check("R10 scl period", 32'(per_m), 16);
        wait_irq(ok);
        wr(3'd4, 1);

        // R9 completion coinciding with a write: set wins
        wr(3'd0, 32'h155);
        @(negedge clk);
        reg_we = 1; reg_addr = 3'd4; reg_wdata = 1;
        seen = 0;
        repeat (400) begin @(negedge clk); if (irq) seen++; end
        reg_we = 0;
        check("R9 coincident set", 32'(seen), 1);
        @(negedge clk);
        check("R9 cleared after", 32'(irq), 0);
        wr(3'd0, 32'h300); wait_irq(ok); wr(3'd4, 1);

        // R8 arbitration loss on address 0x7F (all ones)
        d = 32'(stops);
        wr(3'd0, 32'h5FE);
        @(negedge scl_line);
        other_low = 1;
        wait_irq(ok);
        check("R8 irq", 32'(ok), 1);
        rd(3'd1, d);
        check("R8 lost flag", 32'(d[9]), 1);
        check("R8 held flag", 32'(d[12]), 0);
        @(negedge clk);
        check("R8 drivers off", {30'd0, scl_oe, sda_oe}, 0);
        check("R8 scl high", 32'(scl_line), 1);
        other_low = 0;
        wr(3'd4, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule